// File: doc/BRIEF.md
# Synchronized Multichannel PWM Burst Bank

This block holds a bank of pulse-width-modulated output channels that share one system clock. Each channel carries its own period, high-time and starting offset, all counted in whole clock cycles, so one clock cycle is the time quantum of every waveform. At a 248 MHz clock that quantum is about 4 ns. Settings are written through a small register-style port while the bank is idle.

A single start pulse, qualified by a level gate, launches every channel on the same clock edge. Because each channel's counter begins at its own preloaded offset, the relative phase of all outputs is fixed by configuration and does not depend on when the start arrives. When the gate falls, every output drops low. The next burst begins again from the stored offsets, so consecutive bursts are identical.

Phase resolution equals the period in cycles. A 124-cycle period gives 124 offset steps. The fastest setting, a 2-cycle period, gives only two offset positions.

Top module: `pwm_burst_bank`

## Requirements
- R1: Each of the NUM_CH channels has its own period, high-time and offset registers, and a channel's waveform depends only on its own three settings. A write with `cfg_we` high stores `cfg_data` into the channel selected by `cfg_ch` and the field selected by `cfg_sel` (0 = period, 1 = high-time, 2 = offset).
- R2: After reset every output is low and the bank is idle. The reset settings are period 2, high-time 0 and offset 0.
- R3: While running, a channel's counter advances by one each clock and wraps to 0 after the value period-1. The output is high exactly while the counter is below the high-time value.
- R4: A `start` sampled high together with a high `gate` while idle launches all channels on that edge. In the cycle after that edge each counter equals its offset. A `start` with `gate` low, or while running, has no effect.
- R5: A low `gate` sampled while running stops the bank. All outputs are low from the next cycle, and the next launch restarts every counter from its offset.
- R6: Configuration writes sampled while running, or on the launching edge, are ignored. Settings written while idle apply to the next burst.
- R7: A high-time of 0 gives a constant low output while running. A high-time at or above the effective period gives a constant high output while running.
- R8: Period values 0 and 1 act as a period of 2, which alternates high and low and allows offsets 0 and 1 only.
- R9: A write with `cfg_sel` = 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one cycle is the timing quantum |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel index of the write |
| cfg_sel | input | 2 | Field select: 0 period, 1 high-time, 2 offset, 3 none |
| cfg_data | input | CNT_W | Value written |
| start | input | 1 | Launch pulse |
| gate | input | 1 | Burst enable level; low stops the bank |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The bench builds two copies of the bank, each with eight channels and an 8-bit counter width. The narrow counter keeps periods short, so whole waveform cycles, wraps and restarts fit into a few dozen clocks. One copy decodes the outputs combinationally from the counters (OUT_REG = 0). The other registers them from the next-state values (OUT_REG = 1). Both copies are compared cycle by cycle against the same independent model, which shows that the two output variants produce the same edges on the same cycles.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // Field selector of the configuration port
   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_DUTY   = 2'd1,
      SEL_PHASE  = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

   // Shortest period the counters support, in clock cycles
   localparam int MIN_PERIOD = 2;

endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic gate,
   output logic run_q,
   output logic run_d
);

   // idle -> run only on a gated start; run -> idle when the gate falls
   always_comb begin
      if (run_q) run_d = gate;
      else       run_d = start & gate;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_d;
   end

   AST_LAUNCH_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(start & gate)); // R4

   AST_GATE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !gate) |=> !run_q); // R5

endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int CH_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    busy,
   input  logic                    we,
   input  logic [CH_W-1:0]         ch,
   input  logic [1:0]              sel,
   input  logic [CNT_W-1:0]        data,
   output logic [NUM_CH*CNT_W-1:0] per_flat,
   output logic [NUM_CH*CNT_W-1:0] duty_flat,
   output logic [NUM_CH*CNT_W-1:0] ph_flat
);

   localparam logic [CNT_W-1:0] PER_RST = CNT_W'(MIN_PERIOD);

   logic wr_ok;
   assign wr_ok = we & ~busy;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      logic [CNT_W-1:0] per_q, duty_q, ph_q;

      assign hit = wr_ok && (int'(ch) == g);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            per_q  <= PER_RST;
            duty_q <= '0;
            ph_q   <= '0;
         end else if (hit) begin
            case (sel)
               SEL_PERIOD: per_q  <= data;
               SEL_DUTY:   duty_q <= data;
               SEL_PHASE:  ph_q   <= data;
               default:    ; // SEL_NONE: no field
            endcase
         end
      end

      assign per_flat [g*CNT_W +: CNT_W] = per_q;
      assign duty_flat[g*CNT_W +: CNT_W] = duty_q;
      assign ph_flat  [g*CNT_W +: CNT_W] = ph_q;
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(per_flat) && $stable(duty_flat) && $stable(ph_flat))); // R6

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_q,
   input  logic             run_d,
   input  logic [CNT_W-1:0] per,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] ph,
   output logic             pwm_o
);

   localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

   logic [CNT_W-1:0] eff_per;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             at_last;

   assign eff_per = (per < MIN_P) ? MIN_P : per;
   assign at_last = (cnt_q >= eff_per - CNT_W'(1));

   // Idle and launch both (re)load the offset; running counts and wraps
   always_comb begin
      if (!run_d || !run_q) cnt_d = ph;
      else if (at_last)     cnt_d = '0;
      else                  cnt_d = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   if (OUT_REG) begin : g_out_reg
      logic out_q;
      always_ff @(posedge clk) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= run_d & (cnt_d < duty);
      end
      assign pwm_o = out_q;
   end else begin : g_out_comb
      assign pwm_o = run_q & (cnt_q < duty);
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && run_d && at_last) |=> (cnt_q == '0)); // R3

   AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |-> !pwm_o); // R7

   AST_DUTY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && duty >= eff_per) |-> pwm_o); // R7

endmodule

// File: rtl/pwm_burst_bank.sv
module pwm_burst_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0,
   parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [CNT_W-1:0]  cfg_data,
   input  logic              start,
   input  logic              gate,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int FLAT_W = NUM_CH * CNT_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwm_burst_bank: NUM_CH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("pwm_burst_bank: CNT_W must be at least 2");
   end
   if ((1 << CH_W) < NUM_CH) begin : g_bad_chw
      $error("pwm_burst_bank: CH_W too narrow for NUM_CH");
   end

   logic run_q, run_d;
   logic [FLAT_W-1:0] per_flat, duty_flat, ph_flat;

   pwm_bank_ctrl i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .gate  (gate),
      .run_q (run_q),
      .run_d (run_d)
   );

   pwm_cfg_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .CH_W   (CH_W)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (run_q | run_d),
      .we        (cfg_we),
      .ch        (cfg_ch),
      .sel       (cfg_sel),
      .data      (cfg_data),
      .per_flat  (per_flat),
      .duty_flat (duty_flat),
      .ph_flat   (ph_flat)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      pwm_chan #(
         .CNT_W   (CNT_W),
         .OUT_REG (OUT_REG)
      ) i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .run_q (run_q),
         .run_d (run_d),
         .per   (per_flat [g*CNT_W +: CNT_W]),
         .duty  (duty_flat[g*CNT_W +: CNT_W]),
         .ph    (ph_flat  [g*CNT_W +: CNT_W]),
         .pwm_o (pwm_out[g])
      );
   end

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (pwm_out == '0)); // R5

endmodule

// File: tb/test_pwm_burst_bank.sv
`timescale 1ns/1ps
module test_pwm_burst_bank;

   localparam int CLK_PERIOD = 4;
   localparam int NCH = 8;
   localparam int CW  = 8;

   // rows: {period, duty, phase}, one per channel
   localparam logic [3*CW-1:0] TBL [NCH] = '{
      {8'd10, 8'd3, 8'd0},
      {8'd10, 8'd5, 8'd7},
      {8'd4,  8'd0, 8'd1},   // R7 zero high-time
      {8'd6,  8'd9, 8'd2},   // R7 full high-time
      {8'd0,  8'd1, 8'd0},   // R8 period 0
      {8'd1,  8'd1, 8'd1},   // R8 period 1
      {8'd2,  8'd1, 8'd1},   // R8 period 2
      {8'd7,  8'd6, 8'd6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_ch = '0;
   logic [1:0] cfg_sel = '0;
   logic [CW-1:0] cfg_data = '0;
   logic start = 1'b0;
   logic gate = 1'b0;
   logic [NCH-1:0] out_a, out_b;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [CW-1:0] m_per [NCH];
   logic [CW-1:0] m_duty[NCH];
   logic [CW-1:0] m_ph  [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_burst_bank #(.NUM_CH(NCH), .CNT_W(CW), .OUT_REG(1'b0)) i_pwm_burst_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .start(start), .gate(gate), .pwm_out(out_a));

   pwm_burst_bank #(.NUM_CH(NCH), .CNT_W(CW), .OUT_REG(1'b1)) i_pwm_burst_bank_reg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .start(start), .gate(gate), .pwm_out(out_b));

   function automatic logic [NCH-1:0] model(input int k);
      logic [NCH-1:0] v;
      for (int c = 0; c < NCH; c++) begin
         int eff, cnt;
         eff = (int'(m_per[c]) < 2) ? 2 : int'(m_per[c]);
         cnt = (int'(m_ph[c]) + k) % eff;
         v[c] = (cnt < int'(m_duty[c]));
      end
      return v;
   endfunction

   task automatic chk(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_both(input logic [NCH-1:0] exp, input string tag);
      chk(out_a, exp, {tag, " comb"});
      chk(out_b, exp, {tag, " reg"});
   endtask

   task automatic wr(input int ch, input int sel, input int val);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_data = CW'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic launch();
      gate = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_cycles(input int k0, input int n, input string tag);
      for (int k = k0; k < k0 + n; k++) begin
         chk_both(model(k), tag);
         @(negedge clk);
      end
   endtask

   task automatic stop();
      gate = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (CLK_PERIOD * 200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_per[c] = 8'd2; m_duty[c] = '0; m_ph[c] = '0;
      end
      repeat (3) @(negedge clk);
      chk_both('0, "R2 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_both('0, "R2 after reset");
      // reset settings: high-time 0 -> low even when launched
      launch();
      run_cycles(0, 4, "R2 reset settings");
      stop();

      // Table walk: program every channel, then one long burst
      for (int c = 0; c < NCH; c++) begin
         wr(c, 0, int'(TBL[c][3*CW-1 -: CW]));
         wr(c, 1, int'(TBL[c][2*CW-1 -: CW]));
         wr(c, 2, int'(TBL[c][CW-1 -: CW]));
         m_per[c]  = TBL[c][3*CW-1 -: CW];
         m_duty[c] = TBL[c][2*CW-1 -: CW];
         m_ph[c]   = TBL[c][CW-1 -: CW];
      end
      chk_both('0, "R1 idle after writes");
      launch();
      run_cycles(0, 30, "R1 R3 R4 R7 R8 burst");

      // Gate low: outputs drop, stay low
      stop();
      chk_both('0, "R5 stop");
      @(negedge clk);
      chk_both('0, "R5 stay low");
      // Relaunch restarts from offsets
      launch();
      run_cycles(0, 15, "R5 restart");

      // Start while running and writes while running are ignored
      start = 1'b1;
      chk_both(model(15), "R4 start while running");
      @(negedge clk);
      start = 1'b0;
      run_cycles(16, 4, "R4 no relaunch");
      wr(0, 1, 8);
      run_cycles(21, 10, "R6 write while running");
      stop();
      launch();
      run_cycles(0, 12, "R6 old setting kept");
      stop();

      // Write while idle takes effect on next burst
      wr(0, 1, 8);
      m_duty[0] = 8'd8;
      launch();
      run_cycles(0, 12, "R6 idle write applies");
      stop();

      // Start with gate low has no effect
      gate = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk_both('0, "R4 gate low start");
         @(negedge clk);
      end

      // Selector 3 changes nothing
      wr(1, 3, 0);
      wr(3, 3, 0);
      launch();
      run_cycles(0, 12, "R9 selector 3");
      stop();

      // R8: offset 1 on period-1 channel vs offset 0
      wr(5, 2, 0);
      m_ph[5] = 8'd0;
      launch();
      run_cycles(0, 6, "R8 offset change");
      stop();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule